// File: doc/BRIEF.md
# HDQ Single-Wire Bus Master

This block is the master end of a single-wire HDQ link, exposed through a small bank of byte-wide registers. Software writes a byte into the transmit register and then writes the control register with the start bit set. The block then does one of three things, all on one open-drain line:

- shift the byte out;
- collect one byte driven by the slave;
- hold the line low long enough to reset the slave.

The start bit clears itself when the operation ends. Software learns of the end from a status register that clears when read, and from an interrupt output gated by an enable bit.

Bits travel least-significant first in fixed-length slots. Each slot pulls the line low for a short time to send a one, or for a long time to send a zero, and then releases it. When receiving, the block waits for the slave to pull the line low. It then samples the synchronized line a fixed number of cycles later. If the slave stays silent too long, the block gives up and flags a timeout. A break also ends by raising the timeout flag, which is how software tells that a break has finished. A soft-reset bit returns the block to its idle state. Once that completes, a reset-done flag reads back as 1.

Top module: `hdq_master`

## Requirements
- R1: After reset the line is released and `irq` is low. Control (0x0C) and interrupt status (0x10) read 0x00, and system status (0x18) reads 0x01.
- R2: The revision register at 0x00 reads `{REV_MAJOR, REV_MINOR}`, with the major version in bits 7:4 and the minor version in bits 3:0.
- R3: A write to control (0x0C) with start (bit 4) and clock-enable (bit 5) set, direction (bit 1) and init (bit 2) clear, sends the transmit byte (0x04) least-significant bit first. Each bit takes `SLOT_CYC` cycles. `line_oe` is high for the first `LOW1_CYC` cycles of a slot for a 1 and the first `LOW0_CYC` cycles for a 0, starting in the cycle after the write edge.
- R4: A transmit ends `8*SLOT_CYC` edges after the write edge. On that edge the start bit reads 0 and status bit 2 (transmit done) is set.
- R5: Start and init written together hold `line_oe` high for `BREAK_CYC` cycles. The operation then clears start and init and sets status bit 0 (timeout).
- R6: Start with direction 1 receives a byte, LSB first. For each bit the block waits for a falling edge of the synchronized line, then samples `SAMPLE_CYC` cycles later. After eight bits the byte appears at 0x08, status bit 1 (receive done) is set and start clears.
- R7: During a receive, if no falling edge arrives within `RX_LIMIT` cycles, status bit 0 is set and start clears. This happens exactly `RX_LIMIT` edges after the point where the wait began.
- R8: Reading 0x10 with `rd_en` returns the flags and clears them on that edge. A flag raised on the same edge survives.
- R9: `irq` is high exactly when a status flag is set and interrupt enable (control bit 6) is 1.
- R10: A start request written with clock-enable 0 has no effect: the line stays released and start reads 0.
- R11: Writing system configuration (0x14) bit 1 starts a soft reset lasting `SRST_CYC` cycles. During it, system status reads 0 and configuration bit 1 reads 1. When it ends, reset-done reads 1 and control reads 0x00.
- R12: Autoidle (0x14 bit 0) and mode (0x0C bit 0) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on 0x10) |
| addr | input | 5 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |
| line_oe | output | 1 | Pull the bus line low when 1 |
| line_in | input | 1 | Sampled bus line level |

## Verification
Each timed result is checked on its exact edge, counted from the register write edge:

- a transmit's line pattern starts one cycle after that edge, and completion lands `8*SLOT_CYC` edges after it;
- a break completes `BREAK_CYC` edges after it;
- a receive timeout lands `RX_LIMIT` edges after it;
- soft-reset completion lands `SRST_CYC` edges after it.

The bench compares `line_oe` against a computed waveform on every clock of a transmit or break. It confirms that start still reads 1 one cycle before each deadline and reads 0 on the deadline itself. A receive depends on slave timing, so its results are read once the last slot has passed. The same-edge set-versus-clear rule is tested by issuing a clearing read in the very cycle a break finishes.

// File: rtl/hdq_master.sv
module hdq_master #(
  parameter int REV_MAJOR  = 1,
  parameter int REV_MINOR  = 4,
  parameter int SLOT_CYC   = 40,
  parameter int LOW1_CYC   = 8,
  parameter int LOW0_CYC   = 28,
  parameter int SAMPLE_CYC = 16,
  parameter int BREAK_CYC  = 60,
  parameter int RX_LIMIT   = 200,
  parameter int SRST_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       line_oe,
  input  logic       line_in
);
  localparam int CW = $clog2(SLOT_CYC + BREAK_CYC + RX_LIMIT + SAMPLE_CYC + 1);
  localparam int SW = $clog2(SRST_CYC + 1);
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] BRK_LAST  = CW'(BREAK_CYC - 1);
  localparam logic [CW-1:0] RXW_LAST  = CW'(RX_LIMIT - 1);
  localparam logic [CW-1:0] SMP_LAST  = CW'(SAMPLE_CYC - 1);
  localparam logic [CW-1:0] LOW1      = CW'(LOW1_CYC);
  localparam logic [CW-1:0] LOW0      = CW'(LOW0_CYC);
  localparam logic [SW-1:0] SRST_LAST = SW'(SRST_CYC - 1);
  localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08, A_CTRL = 5'h0C,
                         A_IST = 5'h10, A_SYSC = 5'h14, A_SYSS = 5'h18;

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_TX, S_RXW, S_RXS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    txd, rxd, shreg;
  logic          mode, dir, init, go, clken, ien, autoidle;
  logic [2:0]    istat;
  logic          srst_busy, rstdone;
  logic [SW-1:0] srst_cnt;
  logic          s1, s2, s3;
  logic          busy, rx_fall, tx_done, brk_done, rx_to, rx_done, start, rd_ist;
  logic [2:0]    flag_set;
  logic [CW-1:0] low_len;

  assign busy     = st != S_IDLE;
  assign rx_fall  = st == S_RXW && s3 && !s2;
  assign tx_done  = st == S_TX && cnt == SLOT_LAST && bitn == 3'd7;
  assign brk_done = st == S_BRK && cnt == BRK_LAST;
  assign rx_to    = st == S_RXW && !rx_fall && cnt == RXW_LAST;
  assign rx_done  = st == S_RXS && cnt == SMP_LAST && bitn == 3'd7;
  assign flag_set = {tx_done, rx_done, brk_done | rx_to};
  assign start    = wr_en && addr == A_CTRL && wdata[4] && wdata[5] && !busy;
  assign rd_ist   = rd_en && addr == A_IST;
  assign low_len  = txd[bitn] ? LOW1 : LOW0;
  assign line_oe  = (st == S_BRK) || (st == S_TX && cnt < low_len);
  assign irq      = ien && (istat != 3'b000);

  always_comb begin
    case (addr)
      A_REV:   rdata = {REV_MAJOR[3:0], REV_MINOR[3:0]};
      A_TX:    rdata = txd;
      A_RX:    rdata = rxd;
      A_CTRL:  rdata = {1'b0, ien, clken, go, 1'b0, init, dir, mode};
      A_IST:   rdata = {5'b0, istat};
      A_SYSC:  rdata = {6'b0, srst_busy, autoidle};
      A_SYSS:  rdata = {7'b0, rstdone};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= line_in; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0;
      txd <= '0; rxd <= '0; shreg <= '0;
      mode <= 1'b0; dir <= 1'b0; init <= 1'b0; go <= 1'b0; clken <= 1'b0; ien <= 1'b0;
      autoidle <= 1'b0; istat <= '0;
      srst_busy <= 1'b0; srst_cnt <= '0; rstdone <= 1'b1;
    end else if (srst_busy) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0;
      txd <= '0; rxd <= '0; shreg <= '0;
      mode <= 1'b0; dir <= 1'b0; init <= 1'b0; go <= 1'b0; clken <= 1'b0; ien <= 1'b0;
      istat <= '0;
      if (srst_cnt == SRST_LAST) begin
        srst_busy <= 1'b0;
        rstdone   <= 1'b1;
      end else begin
        srst_cnt <= srst_cnt + 1'b1;
      end
    end else begin
      istat <= (rd_ist ? 3'b000 : istat) | flag_set;
      if (wr_en && addr == A_SYSC) begin
        autoidle <= wdata[0];
        if (wdata[1]) begin
          srst_busy <= 1'b1;
          srst_cnt  <= '0;
          rstdone   <= 1'b0;
        end
      end
      if (wr_en && addr == A_TX && !busy) txd <= wdata;
      if (wr_en && addr == A_CTRL) begin
        mode  <= wdata[0];
        dir   <= wdata[1];
        clken <= wdata[5];
        ien   <= wdata[6];
        if (!busy) begin
          go   <= start;
          init <= start && wdata[2];
        end
      end
      case (st)
        S_IDLE: if (start) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= wdata[2] ? S_BRK : (wdata[1] ? S_RXW : S_TX);
        end
        S_BRK: if (cnt == BRK_LAST) begin
          st <= S_IDLE; go <= 1'b0; init <= 1'b0;
        end else cnt <= cnt + 1'b1;
        S_TX: if (cnt == SLOT_LAST) begin
          cnt <= '0;
          if (bitn == 3'd7) begin
            st <= S_IDLE; go <= 1'b0;
          end else bitn <= bitn + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_RXW: if (rx_fall) begin
          st <= S_RXS; cnt <= '0;
        end else if (cnt == RXW_LAST) begin
          st <= S_IDLE; go <= 1'b0;
        end else cnt <= cnt + 1'b1;
        S_RXS: if (cnt == SMP_LAST) begin
          cnt <= '0;
          shreg[bitn] <= s2;
          if (bitn == 3'd7) begin
            st <= S_IDLE; go <= 1'b0;
            rxd <= {s2, shreg[6:0]};
          end else begin
            bitn <= bitn + 1'b1;
            st   <= S_RXW;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdq_master_chk.sv
module hdq_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [4:0] addr,
  input logic [7:0] wdata,
  input logic       irq,
  input logic       line_oe,
  input logic       ien,
  input logic       go,
  input logic       busy,
  input logic       srst_busy,
  input logic [2:0] istat,
  input logic [2:0] flag_set
);
  // R10
  clken_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h0C && !wdata[5] && !busy && !srst_busy) |=> !busy);

  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  // R4
  go_done_chk: assert property (@(posedge clk) disable iff (!rst_n || srst_busy)
    $fell(go) |-> (istat != 3'b000));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'h10 && flag_set == 3'b000 && !srst_busy) |=> (istat == 3'b000));

  // R11
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && $past(srst_busy)) |-> (!busy && !line_oe));

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);
endmodule

bind hdq_master hdq_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .irq(irq), .line_oe(line_oe), .ien(ien), .go(go), .busy(busy),
  .srst_busy(srst_busy), .istat(istat), .flag_set(flag_set)
);

// File: tb/hdq_master_bench.sv
module hdq_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 40, LOW1 = 8, LOW0 = 28, SAMPLE = 16, BRK = 60, RXLIM = 200, SRST = 4;

  logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, slave_low = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq, line_oe, line_in;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] v;
  bit         done = 0;

  assign line_in = !(line_oe || slave_low);
  always #(CLK_PERIOD/2) clk = ~clk;

  hdq_master #(.REV_MAJOR(1), .REV_MINOR(4), .SLOT_CYC(SLOT), .LOW1_CYC(LOW1), .LOW0_CYC(LOW0),
    .SAMPLE_CYC(SAMPLE), .BREAK_CYC(BRK), .RX_LIMIT(RXLIM), .SRST_CYC(SRST)) u_hdq_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .line_oe(line_oe), .line_in(line_in));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1; #1;
    d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    addr = a; #1;
    d = rdata;
  endtask

  function automatic bit tx_oe(input logic [7:0] b, input int j);
    int pos = j % SLOT;
    return pos < (b[j / SLOT] ? LOW1 : LOW0);
  endfunction

  task automatic send_tx(input logic [7:0] b, input logic [7:0] ctl);
    wr(5'h04, b);
    wr(5'h0C, ctl);
    for (int j = 0; j < 8 * SLOT; j++) begin
      chk("R3 line_oe", line_oe, tx_oe(b, j));
      if (j == 8 * SLOT - 1) begin
        peek(5'h0C, v); chk("R4 start busy", v[4], 1);
      end
      @(negedge clk);
    end
    peek(5'h0C, v); chk("R4 start cleared", v[4], 0);
  endtask

  task automatic slave_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      slave_low = 1;
      repeat (b[i] ? LOW1 : LOW0) @(negedge clk);
      slave_low = 0;
      repeat (SLOT - (b[i] ? LOW1 : LOW0)) @(negedge clk);
    end
  endtask

  task automatic recv(input logic [7:0] b);
    wr(5'h0C, 8'h72);
    peek(5'h0C, v); chk("R6 start set", v, 8'h72);
    repeat (5) @(negedge clk);
    slave_byte(b);
    repeat (10) @(negedge clk);
    chk("R9 irq rx", irq, 1);
    peek(5'h0C, v); chk("R6 start cleared", v, 8'h62);
    rd(5'h10, v); chk("R6 rx flag", v, 8'h02);
    rd(5'h08, v); chk("R6 rx byte", v, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 line_oe", line_oe, 0);
    chk("R1 irq", irq, 0);
    peek(5'h0C, v); chk("R1 ctrl", v, 0);
    peek(5'h10, v); chk("R1 status", v, 0);
    peek(5'h18, v); chk("R1 reset done", v, 1);
    // R2
    peek(5'h00, v); chk("R2 revision", v, 8'h14);

    // R10: start without clock enable
    wr(5'h0C, 8'h10);
    for (int k = 0; k < 20; k++) begin
      chk("R10 line idle", line_oe, 0);
      @(negedge clk);
    end
    peek(5'h0C, v); chk("R10 start ignored", v, 0);

    // R3 R4, interrupt disabled
    send_tx(8'hA5, 8'h30);
    chk("R9 irq masked", irq, 0);
    rd(5'h10, v); chk("R4 tx flag", v, 8'h04);
    rd(5'h10, v); chk("R8 cleared", v, 0);

    // R9 with enable
    wr(5'h0C, 8'h60);
    send_tx(8'h3C, 8'h70);
    chk("R9 irq tx", irq, 1);
    rd(5'h10, v); chk("R4 tx flag 2", v, 8'h04);
    chk("R9 irq cleared", irq, 0);

    // R5 break, R8 same-edge set
    wr(5'h0C, 8'h74);
    for (int j = 0; j < BRK - 1; j++) begin
      chk("R5 break low", line_oe, 1);
      @(negedge clk);
    end
    chk("R5 break low end", line_oe, 1);
    peek(5'h0C, v); chk("R5 init held", v, 8'h74);
    rd(5'h10, v); chk("R8 read before set", v, 0);
    chk("R5 released", line_oe, 0);
    peek(5'h0C, v); chk("R5 init/start cleared", v, 8'h60);
    chk("R9 irq break", irq, 1);
    rd(5'h10, v); chk("R8 set wins", v, 8'h01);

    // R6
    recv(8'h96);
    recv(8'h41);

    // R7 receive timeout
    wr(5'h0C, 8'h72);
    repeat (RXLIM - 1) @(negedge clk);
    peek(5'h0C, v); chk("R7 still waiting", v[4], 1);
    @(negedge clk);
    peek(5'h0C, v); chk("R7 start cleared", v[4], 0);
    rd(5'h10, v); chk("R7 timeout flag", v, 8'h01);

    // R12
    wr(5'h0C, 8'h21);
    peek(5'h0C, v); chk("R12 mode", v, 8'h21);
    wr(5'h14, 8'h01);
    peek(5'h14, v); chk("R12 autoidle", v, 8'h01);

    // R11 soft reset
    wr(5'h0C, 8'h60);
    wr(5'h14, 8'h03);
    peek(5'h18, v); chk("R11 busy status", v, 0);
    peek(5'h14, v); chk("R11 busy config", v, 8'h03);
    repeat (SRST - 1) @(negedge clk);
    peek(5'h18, v); chk("R11 not yet done", v, 0);
    @(negedge clk);
    peek(5'h18, v); chk("R11 reset done", v, 1);
    peek(5'h14, v); chk("R11 config after", v, 8'h01);
    peek(5'h0C, v); chk("R11 ctrl cleared", v, 0);

    finish_run();
  end
endmodule